// File: doc/BRIEF.md
# Interrupt Pin Router with Indexed Register Window

This block collects 24 interrupt input pins and turns each qualifying pin event into a message on a valid/ready output. The message carries an 8-bit vector, a destination mode bit and an 8-bit destination ID. Each pin is governed by a 64-bit routing entry that sets its vector, its mask, its active polarity, its trigger mode (edge or level) and where its message goes.

Software does not address the internal registers directly. It first writes an internal index into a select register, and then reads or writes that register through a data window. The internal space holds an identification register, a read-only version register and the routing table. Each 64-bit entry is split into a low half and a high half at two consecutive indices.

Level-triggered pins use a handshake with the interrupt consumer. After a message is sent, the pin is blocked until an end-of-interrupt notice that carries the same vector clears a per-pin in-service flag. When several pins have requests waiting, they are served lowest pin first.

Top module: `irq_router`

## Requirements
- R1: A write at byte offset 0x00 loads the 8-bit internal index from wdata[7:0], and a read at 0x00 returns that index zero-extended. Reads and writes at byte offset 0x10 reach the internal register the index selects. Other offsets read zero and ignore writes.
- R2: Index 0x00 holds a 4-bit ID in bits 27:24, which is zero after reset and writable. All other bits of this register read zero.
- R3: Index 0x01 is read-only and reads 0x0017_0020. Bits 7:0 hold the version 0x20, bits 23:16 hold the highest entry number 23, and all other bits are zero.
- R4: The low half of entry i is at index 0x10+2i and the high half is at index 0x11+2i. The low-half fields are: vector in bits 7:0, destination mode in bit 11, polarity in bit 13 (1 = active low), in-service flag in bit 14 (read-only), trigger mode in bit 15 (1 = level) and mask in bit 16. The destination ID is in bits 31:24 of the high half. Unlisted bits read zero. After reset each low half reads 0x0001_0000 and each high half reads 0. Indices 0x02–0x0F and 0x40–0xFF read zero.
- R5: While an entry's mask bit is set, activity on its pin produces no message.
- R6: An unmasked edge-mode pin produces exactly one message for each inactive-to-active transition of its input after the polarity is applied. A pin held active does not produce further messages.
- R7: A message presents the entry's vector, destination mode and destination ID. It stays valid and unchanged until it is accepted by msg_ready_i.
- R8: Any number of further edges on a pin, while that pin's earlier request is waiting, are kept as one additional message.
- R9: When several pins have requests waiting, the lowest-numbered pin is sent first.
- R10: A level-mode pin sends one message and sets its in-service flag. It then sends nothing more until that flag is cleared.
- R11: An end-of-interrupt notice clears the in-service flag of every level-mode entry whose vector equals the notice's vector. A notice with a different vector has no effect. If the pin is still active after the flag is cleared, a new message follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Byte offset: 0x00 for the index, 0x10 for the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_i | input | 24 | Interrupt pins |
| eoi_valid_i | input | 1 | End-of-interrupt notice strobe |
| eoi_vector_i | input | 8 | Vector carried by the notice |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted when high together with valid |
| msg_vector_o | output | 8 | Message vector |
| msg_dest_mode_o | output | 1 | Message destination mode |
| msg_dest_id_o | output | 8 | Message destination ID |

## Verification
The hardest state to reach from the ports is a second request stacked behind a waiting one. The bench holds msg_ready_i low, lets the first pulse fill the output register, and then pulses the same pin several more times. Releasing ready must then yield exactly two messages. The priority case uses the same stall: two pins rise in the same cycle, and the bench checks the order in which they drain. For the in-service flag, the bench reads bit 14 back through the window, sends a notice with a wrong vector and then one with the right vector, and confirms that a still-active pin sends again.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;   // 1 = level
    logic       pol;    // 1 = active low
    logic       dmode;
    logic [7:0] vector;
  } rte_t;

  localparam logic [4:0] ADDR_SEL = 5'h00;
  localparam logic [4:0] ADDR_WIN = 5'h10;
  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam int unsigned TBL_BASE = 16;

  localparam rte_t RTE_RESET = '{dest: 8'h00, mask: 1'b1, trig: 1'b0,
                                 pol: 1'b0, dmode: 1'b0, vector: 8'h00};

endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter logic [3:0]  ID_RESET = 4'h0,
  parameter logic [7:0]  VERSION  = 8'h20
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_we_i,
  input  logic [4:0]            bus_addr_i,
  input  logic [31:0]           bus_wdata_i,
  output logic [31:0]           bus_rdata_o,
  input  logic [NUM_PINS-1:0]   rirr_i,
  output rte_t [NUM_PINS-1:0]   rte_o
);

  localparam logic [7:0] MAX_ENTRY = 8'(NUM_PINS - 1);

  logic [7:0]  sel_q;
  logic [3:0]  id_q;
  logic        sel_we, win_we;
  logic [31:0] win_data;
  logic        unused_wdata;

  assign sel_we = bus_we_i && (bus_addr_i == ADDR_SEL);
  assign win_we = bus_we_i && (bus_addr_i == ADDR_WIN);
  assign unused_wdata = ^{bus_wdata_i[23:17], bus_wdata_i[14], bus_wdata_i[12], bus_wdata_i[10:8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= ID_RESET;
    end else begin
      if (sel_we) sel_q <= bus_wdata_i[7:0];
      if (win_we && sel_q == IDX_ID) id_q <= bus_wdata_i[27:24];
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_entry
    localparam logic [7:0] LO_IDX = 8'(TBL_BASE + 2 * g);
    localparam logic [7:0] HI_IDX = 8'(TBL_BASE + 2 * g + 1);
    rte_t rte_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rte_q <= RTE_RESET;
      end else if (win_we) begin
        if (sel_q == LO_IDX) begin
          rte_q.vector <= bus_wdata_i[7:0];
          rte_q.dmode  <= bus_wdata_i[11];
          rte_q.pol    <= bus_wdata_i[13];
          rte_q.trig   <= bus_wdata_i[15];
          rte_q.mask   <= bus_wdata_i[16];
        end
        if (sel_q == HI_IDX) rte_q.dest <= bus_wdata_i[31:24];
      end
    end

    assign rte_o[g] = rte_q;
  end

  always_comb begin
    win_data = '0;
    if (sel_q == IDX_ID)  win_data = {4'h0, id_q, 24'h0};
    if (sel_q == IDX_VER) win_data = {8'h00, MAX_ENTRY, 8'h00, VERSION};
    for (int k = 0; k < NUM_PINS; k++) begin
      if (sel_q == 8'(TBL_BASE + 2 * k))
        win_data = {15'h0, rte_o[k].mask, rte_o[k].trig, rirr_i[k], rte_o[k].pol,
                    1'b0, rte_o[k].dmode, 3'h0, rte_o[k].vector};
      if (sel_q == 8'(TBL_BASE + 2 * k + 1))
        win_data = {rte_o[k].dest, 24'h0};
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_SEL) bus_rdata_o = {24'h0, sel_q};
    else if (bus_addr_i == ADDR_WIN) bus_rdata_o = win_data;
  end

  assert_sel_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we |=> sel_q == $past(bus_wdata_i[7:0]));

  assert_id_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_we && sel_q == IDX_ID) |=> id_q == $past(bus_wdata_i[27:24]));

  assert_id_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_we |=> $stable(id_q));

endmodule

// File: rtl/irq_pin.sv
module irq_pin (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  logic       mask_i,
  input  logic       trig_i,
  input  logic       pol_i,
  input  logic [7:0] vector_i,
  input  logic       grant_i,
  input  logic       eoi_valid_i,
  input  logic [7:0] eoi_vector_i,
  output logic       req_o,
  output logic       rirr_o
);

  logic raw_q, act, act_q, rise, pend_q, rirr_q;

  assign act  = raw_q ^ pol_i;
  assign rise = act & ~act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= 1'b0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      raw_q <= irq_i;
      act_q <= act;
      if (trig_i) pend_q <= 1'b0;
      else        pend_q <= (pend_q & ~grant_i) | (rise & ~mask_i);
      if (!trig_i)                                       rirr_q <= 1'b0;
      else if (grant_i)                                  rirr_q <= 1'b1;
      else if (eoi_valid_i && eoi_vector_i == vector_i)  rirr_q <= 1'b0;
    end
  end

  assign req_o  = ~mask_i & (trig_i ? (act & ~rirr_q) : pend_q);
  assign rirr_o = rirr_q;

  assert_grant_has_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> req_o);

  assert_level_sets_rirr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && trig_i) |=> rirr_o);

  assert_pending_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !grant_i && !trig_i) |=> pend_q);

  assert_rirr_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rirr_o) && $past(trig_i)) |-> $past(eoi_valid_i && eoi_vector_i == vector_i));

endmodule

// File: rtl/irq_send.sv
module irq_send #(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       req_i,
  input  logic [NUM_PINS-1:0][7:0]  vector_i,
  input  logic [NUM_PINS-1:0]       dmode_i,
  input  logic [NUM_PINS-1:0][7:0]  dest_i,
  output logic [NUM_PINS-1:0]       grant_o,
  output logic                      msg_valid_o,
  input  logic                      msg_ready_i,
  output logic [7:0]                msg_vector_o,
  output logic                      msg_dest_mode_o,
  output logic [7:0]                msg_dest_id_o
);

  localparam int unsigned PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [PIN_W-1:0] pick;
  logic             found, load;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (!found && req_i[i]) begin
        found = 1'b1;
        pick  = PIN_W'(i);
      end
    end
  end

  assign load = found && (!msg_valid_o || msg_ready_i);

  always_comb begin
    grant_o = '0;
    if (load) grant_o[pick] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o     <= 1'b0;
      msg_vector_o    <= '0;
      msg_dest_mode_o <= 1'b0;
      msg_dest_id_o   <= '0;
    end else if (load) begin
      msg_valid_o     <= 1'b1;
      msg_vector_o    <= vector_i[pick];
      msg_dest_mode_o <= dmode_i[pick];
      msg_dest_id_o   <= dest_i[pick];
    end else if (msg_ready_i) begin
      msg_valid_o <= 1'b0;
    end
  end

  assert_grant_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  assert_msg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_vector_o)
      && $stable(msg_dest_mode_o) && $stable(msg_dest_id_o)));

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter logic [3:0]  ID_RESET = 4'h0,
  parameter logic [7:0]  VERSION  = 8'h20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic [4:0]           bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic [NUM_PINS-1:0]  irq_i,
  input  logic                 eoi_valid_i,
  input  logic [7:0]           eoi_vector_i,
  output logic                 msg_valid_o,
  input  logic                 msg_ready_i,
  output logic [7:0]           msg_vector_o,
  output logic                 msg_dest_mode_o,
  output logic [7:0]           msg_dest_id_o
);

  rte_t [NUM_PINS-1:0]      rte;
  logic [NUM_PINS-1:0]      req, grant, rirr, dmode;
  logic [NUM_PINS-1:0][7:0] vec, dest;

  irq_regs #(.NUM_PINS(NUM_PINS), .ID_RESET(ID_RESET), .VERSION(VERSION)) i_regs (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .rirr_i(rirr), .rte_o(rte)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign vec[g]   = rte[g].vector;
    assign dmode[g] = rte[g].dmode;
    assign dest[g]  = rte[g].dest;

    irq_pin i_pin (
      .clk_i, .rst_ni,
      .irq_i(irq_i[g]), .mask_i(rte[g].mask), .trig_i(rte[g].trig), .pol_i(rte[g].pol),
      .vector_i(rte[g].vector), .grant_i(grant[g]),
      .eoi_valid_i, .eoi_vector_i,
      .req_o(req[g]), .rirr_o(rirr[g])
    );
  end

  irq_send #(.NUM_PINS(NUM_PINS)) i_send (
    .clk_i, .rst_ni, .req_i(req), .vector_i(vec), .dmode_i(dmode), .dest_i(dest),
    .grant_o(grant), .msg_valid_o, .msg_ready_i, .msg_vector_o, .msg_dest_mode_o,
    .msg_dest_id_o
  );

endmodule

// File: tb/test_irq_router.sv
module test_irq_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [23:0] irq = '0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        msg_valid, msg_ready = 1'b1, msg_dm;
  logic [7:0]  msg_vec, msg_dest;

  int errors = 0;
  int checks = 0;
  int msg_cnt = 0;
  logic [7:0] log_vec [0:63];
  logic       log_dm  [0:63];
  logic [7:0] log_dest[0:63];
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_router i_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_i(irq),
    .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vector),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready), .msg_vector_o(msg_vec),
    .msg_dest_mode_o(msg_dm), .msg_dest_id_o(msg_dest)
  );

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      log_vec[msg_cnt[5:0]]  <= msg_vec;
      log_dm[msg_cnt[5:0]]   <= msg_dm;
      log_dest[msg_cnt[5:0]] <= msg_dest;
      msg_cnt <= msg_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [31:0] d);
    bus_wr(5'h00, {24'h0, idx});
    bus_wr(5'h10, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [31:0] d);
    bus_wr(5'h00, {24'h0, idx});
    bus_addr = 5'h10;
    #1 d = bus_rdata;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(posedge clk); #1;
    eoi_valid = 1'b1; eoi_vector = v;
    @(posedge clk); #1;
    eoi_valid = 1'b0;
  endtask

  task automatic pulse(input int pin);
    irq[pin] = 1'b1; cyc(3);
    irq[pin] = 1'b0; cyc(3);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R7 reset msg_valid", {31'h0, msg_valid}, 32'h0);
    bus_addr = 5'h00; #1;
    check("R1 reset index", bus_rdata, 32'h0);
    reg_rd(8'h00, d); check("R2 reset id", d, 32'h0);
    reg_rd(8'h01, d); check("R3 version", d, 32'h0017_0020);
    reg_rd(8'h10, d); check("R4 reset entry0 lo", d, 32'h0001_0000);
    reg_rd(8'h11, d); check("R4 reset entry0 hi", d, 32'h0);
    reg_rd(8'h3E, d); check("R4 reset entry23 lo", d, 32'h0001_0000);
    reg_rd(8'h3F, d); check("R4 reset entry23 hi", d, 32'h0);
  endtask

  task automatic t_window;
    logic [31:0] d;
    reg_wr(8'h00, 32'hFFFF_FFFF);
    reg_rd(8'h00, d); check("R2 id write", d, 32'h0F00_0000);
    reg_wr(8'h01, 32'h0);
    reg_rd(8'h01, d); check("R3 version read-only", d, 32'h0017_0020);
    reg_rd(8'h05, d); check("R4 undefined 0x05", d, 32'h0);
    reg_rd(8'h40, d); check("R4 undefined 0x40", d, 32'h0);
    bus_addr = 5'h00; #1;
    check("R1 index readback", bus_rdata, 32'h40);
    bus_addr = 5'h08; #1;
    check("R1 other offset", bus_rdata, 32'h0);
    reg_wr(8'h1A, 32'hFFFF_FFFF);
    reg_rd(8'h1A, d); check("R4 entry5 lo fields", d, 32'h0001_A8FF);
    reg_wr(8'h1B, 32'hFFFF_FFFF);
    reg_rd(8'h1B, d); check("R4 entry5 hi fields", d, 32'hFF00_0000);
    reg_wr(8'h1A, 32'h0001_0000);
    reg_wr(8'h1B, 32'h0);
  endtask

  task automatic t_masked;
    int c0 = msg_cnt;
    pulse(1); cyc(8);
    check("R5 masked pin count", msg_cnt, c0);
    check("R5 masked pin valid", {31'h0, msg_valid}, 32'h0);
  endtask

  task automatic t_edge;
    int c0;
    reg_wr(8'h17, 32'h0500_0000);
    reg_wr(8'h16, 32'h0000_0833);
    cyc(4);
    c0 = msg_cnt;
    irq[3] = 1'b1; cyc(20);
    check("R6 one msg per edge while held", msg_cnt, c0 + 1);
    check("R7 vector", log_vec[c0[5:0]], 32'h33);
    check("R7 dest mode", log_dm[c0[5:0]], 32'h1);
    check("R7 dest id", log_dest[c0[5:0]], 32'h05);
    irq[3] = 1'b0; cyc(10);
    check("R6 no msg on falling", msg_cnt, c0 + 1);
    irq[4] = 1'b1;
    reg_wr(8'h18, 32'h0000_2044);
    cyc(6);
    check("R6 active-low idle", msg_cnt, c0 + 1);
    irq[4] = 1'b0; cyc(10);
    check("R6 active-low edge count", msg_cnt, c0 + 2);
    check("R6 active-low vector", log_vec[6'(c0 + 1)], 32'h44);
  endtask

  task automatic t_collapse;
    int c0 = msg_cnt;
    msg_ready = 1'b0;
    pulse(3); pulse(3); pulse(3);
    check("R7 waiting msg valid", {31'h0, msg_valid}, 32'h1);
    check("R7 waiting vector", msg_vec, 32'h33);
    msg_ready = 1'b1; cyc(12);
    check("R8 collapsed edges count", msg_cnt, c0 + 2);
  endtask

  task automatic t_priority;
    int c0;
    reg_wr(8'h22, 32'h0000_0059);
    reg_wr(8'h14, 32'h0000_0052);
    cyc(4);
    c0 = msg_cnt;
    msg_ready = 1'b0;
    irq[9] = 1'b1; irq[2] = 1'b1; cyc(8);
    msg_ready = 1'b1; cyc(10);
    check("R9 two msgs", msg_cnt, c0 + 2);
    check("R9 first lowest pin", log_vec[c0[5:0]], 32'h52);
    check("R9 second", log_vec[6'(c0 + 1)], 32'h59);
    irq[9] = 1'b0; irq[2] = 1'b0; cyc(4);
  endtask

  task automatic t_level;
    int c0;
    logic [31:0] d;
    reg_wr(8'h1C, 32'h0000_8046);
    cyc(4);
    c0 = msg_cnt;
    irq[6] = 1'b1; cyc(10);
    check("R10 level first msg", msg_cnt, c0 + 1);
    check("R10 level vector", log_vec[c0[5:0]], 32'h46);
    reg_rd(8'h1C, d); check("R10 in-service flag set", d, 32'h0000_C046);
    cyc(10);
    check("R10 no repeat while in service", msg_cnt, c0 + 1);
    send_eoi(8'h47); cyc(10);
    check("R11 wrong vector no msg", msg_cnt, c0 + 1);
    reg_rd(8'h1C, d); check("R11 wrong vector keeps flag", d, 32'h0000_C046);
    send_eoi(8'h46); cyc(10);
    check("R11 still active resends", msg_cnt, c0 + 2);
    irq[6] = 1'b0; cyc(4);
    send_eoi(8'h46); cyc(10);
    reg_rd(8'h1C, d); check("R11 flag cleared", d, 32'h0000_8046);
    check("R11 inactive no msg", msg_cnt, c0 + 2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_window();
    t_masked();
    t_edge();
    t_collapse();
    t_priority();
    t_level();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule